// File: doc/BRIEF.md
# Scoreboard Issue Controller

This block is the hazard bookkeeping for a core with several parallel, unpipelined functional units. Instructions reach it one at a time, in program order. Each is a decoded three-address operation: a unit kind, a destination register and two source registers. The controller dispatches an instruction to a free unit of the right kind only when no other instruction already owns a pending write to its destination. It then tells each unit when both operands are ready to read. It grants write-back only when no earlier instruction still has to read the old value of the destination.

Every unit records its operation's three register numbers, the unit producing each source, and a ready flag per source. When a unit writes back, its destination's pending mark is cleared, and waiting sources that named it become ready in that same cycle. The functional units are fixed-latency counters inside the block. Unit `i` runs for `BASE_LAT + LAT_STEP*i` cycles, so results finish out of order. Unit `i` serves kind `i % NKIND`.

Top module: `sb_issue_ctl`

## Requirements
- R1: After a synchronous reset every unit is idle and no register is pending; with `in_valid` low, `disp_fire`, `opr_go` and `wb_go` are all zero.
- R2: The presented instruction is dispatched (`disp_fire` high, same cycle, combinational) exactly when `in_valid` is high, a unit of kind `in_kind` is idle and `in_dst` has no pending write; otherwise it is held and later instructions wait behind it.
- R3: With every unit of the requested kind busy, dispatch stalls.
- R4: With a write pending on `in_dst`, dispatch stalls, so each register has at most one outstanding writer.
- R5: Dispatch picks the lowest-numbered idle unit whose index modulo `NKIND` equals `in_kind`, reported on `disp_unit`.
- R6: `opr_go[i]` pulses once per dispatched instruction, in the first cycle after dispatch in which both of its sources are ready; instructions in different units may read out of program order.
- R7: A unit's result becomes eligible for write-back `BASE_LAT + LAT_STEP*i` cycles after its `opr_go` pulse.
- R8: Write-back of unit `i` is withheld while any other busy unit has not yet read its operands and holds a ready source whose register number equals unit `i`'s destination.
- R9: At most one `wb_go` bit is high per cycle; among eligible units the lowest index wins, and `wb_reg` gives the destination written.
- R10: A write-back clears the destination's pending mark and frees the unit for the next cycle; sources waiting on that unit, including those of an instruction dispatched in the same cycle, become ready at once, so their `opr_go` can pulse in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented |
| in_kind | input | KIND_W | Functional-unit kind required |
| in_dst | input | 3 | Destination register number |
| in_srca | input | 3 | First source register number |
| in_srcb | input | 3 | Second source register number |
| disp_fire | output | 1 | Presented instruction is dispatched this cycle |
| disp_unit | output | UW | Unit receiving the instruction |
| opr_go | output | NFU | Per unit: read operands and start execution |
| wb_go | output | NFU | Per unit: write result back this cycle |
| wb_reg | output | 3 | Register written by the granted unit |

## Verification
The bench builds a scenario in which a fast unit finishes while a slower, earlier instruction still waits to read the fast unit's destination. A design that ignored that hold would grant write-back at once and corrupt the reader's operand. Back-to-back writes to one register check the single-writer stall; without it, the second writer would overwrite the first's producer record and strand its readers. A long random stream creates cycles where several units finish together, so a wrong priority shows up as a mismatched grant. The same stream dispatches instructions whose source is being written back that very cycle. A design that missed that same-cycle release would leave the source waiting forever.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int REG_W = 3;
  localparam int NREG  = 1 << REG_W;
  typedef logic [REG_W-1:0] reg_id_t;
endpackage

// File: rtl/sb_pick.sv
module sb_pick #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    gnt = '0;
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        gnt[i] = 1'b1;
        any    = 1'b1;
        idx    = IW'(i);
      end
    end
  end
endmodule

// File: rtl/sb_fu_stub.sv
module sb_fu_stub #(
  parameter int LAT = 2,
  parameter int CW  = (LAT > 1) ? $clog2(LAT) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic release_i,
  output logic done
);
  logic          run;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (release_i) begin
      run <= 1'b0;
    end else if (start) begin
      run <= 1'b1;
      cnt <= CW'(LAT - 1);
    end else if (run && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = run && (cnt == '0);
endmodule

// File: rtl/sb_issue_ctl.sv
module sb_issue_ctl
  import sb_pkg::*;
#(
  parameter int NFU      = 4,
  parameter int NKIND    = 2,
  parameter int KIND_W   = 1,
  parameter int BASE_LAT = 2,
  parameter int LAT_STEP = 2,
  parameter int UW       = (NFU > 1) ? $clog2(NFU) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [KIND_W-1:0] in_kind,
  input  logic [2:0]        in_dst,
  input  logic [2:0]        in_srca,
  input  logic [2:0]        in_srcb,
  output logic              disp_fire,
  output logic [UW-1:0]     disp_unit,
  output logic [NFU-1:0]    opr_go,
  output logic [NFU-1:0]    wb_go,
  output logic [2:0]        wb_reg
);
  logic [NFU-1:0]  busy, rdn, rj, rk, done;
  reg_id_t         fi [NFU];
  reg_id_t         fj [NFU];
  reg_id_t         fk [NFU];
  logic [UW-1:0]   qj [NFU];
  logic [UW-1:0]   qk [NFU];
  logic [NREG-1:0] pend;
  logic [UW-1:0]   prod [NREG];

  logic [NFU-1:0]  free_req, free_gnt, war_hold, wb_req;
  logic            free_any, wb_any;
  logic [UW-1:0]   free_idx, wb_idx;
  logic            rdy_a, rdy_b;

  for (genvar g = 0; g < NFU; g++) begin : g_unit
    assign free_req[g] = !busy[g] && (in_kind == KIND_W'(g % NKIND));
    sb_fu_stub #(.LAT(BASE_LAT + LAT_STEP * g)) u_stub (
      .clk(clk), .rst(rst), .start(opr_go[g]),
      .release_i(wb_go[g]), .done(done[g])
    );
  end

  sb_pick #(.N(NFU), .IW(UW)) u_free_pick (
    .req(free_req), .gnt(free_gnt), .any(free_any), .idx(free_idx)
  );

  always_comb begin
    for (int i = 0; i < NFU; i++) begin
      war_hold[i] = 1'b0;
      for (int f = 0; f < NFU; f++) begin
        if (busy[f] && !rdn[f] &&
            ((rj[f] && fj[f] == fi[i]) || (rk[f] && fk[f] == fi[i])))
          war_hold[i] = 1'b1;
      end
    end
  end

  assign wb_req = busy & done & ~war_hold;

  sb_pick #(.N(NFU), .IW(UW)) u_wb_pick (
    .req(wb_req), .gnt(wb_go), .any(wb_any), .idx(wb_idx)
  );

  assign wb_reg    = wb_any ? fi[wb_idx] : '0;
  assign opr_go    = busy & ~rdn & rj & rk;
  assign disp_fire = in_valid && free_any && !pend[in_dst];
  assign disp_unit = free_idx;
  assign rdy_a     = !pend[in_srca] || (wb_any && fi[wb_idx] == in_srca);
  assign rdy_b     = !pend[in_srcb] || (wb_any && fi[wb_idx] == in_srcb);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= '0;
      rdn  <= '0;
      rj   <= '0;
      rk   <= '0;
      pend <= '0;
      for (int i = 0; i < NFU; i++) begin
        fi[i] <= '0; fj[i] <= '0; fk[i] <= '0;
        qj[i] <= '0; qk[i] <= '0;
      end
      for (int r = 0; r < NREG; r++) prod[r] <= '0;
    end else begin
      for (int i = 0; i < NFU; i++) begin
        if (opr_go[i]) rdn[i] <= 1'b1;
        if (wb_go[i]) begin
          busy[i] <= 1'b0;
          rdn[i]  <= 1'b0;
        end
        if (wb_any && busy[i] && qj[i] == wb_idx) rj[i] <= 1'b1;
        if (wb_any && busy[i] && qk[i] == wb_idx) rk[i] <= 1'b1;
      end
      if (wb_any) pend[fi[wb_idx]] <= 1'b0;
      if (disp_fire) begin
        busy[free_idx] <= 1'b1;
        rdn[free_idx]  <= 1'b0;
        fi[free_idx]   <= in_dst;
        fj[free_idx]   <= in_srca;
        fk[free_idx]   <= in_srcb;
        qj[free_idx]   <= prod[in_srca];
        qk[free_idx]   <= prod[in_srcb];
        rj[free_idx]   <= rdy_a;
        rk[free_idx]   <= rdy_b;
        pend[in_dst]   <= 1'b1;
        prod[in_dst]   <= free_idx;
      end
    end
  end
endmodule

// File: rtl/sb_issue_chk.sv
module sb_issue_chk #(
  parameter int NFU = 4,
  parameter int UW  = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           disp_fire,
  input logic [UW-1:0]  disp_unit,
  input logic [2:0]     in_dst,
  input logic [NFU-1:0] opr_go,
  input logic [NFU-1:0] wb_go,
  input logic [2:0]     wb_reg,
  input logic [NFU-1:0] busy,
  input logic [7:0]     pend
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (busy == '0 && pend == '0));

  p_unit_free_r3: assert property (@(posedge clk) disable iff (rst)
    disp_fire |-> !busy[disp_unit]);

  p_no_waw_r4: assert property (@(posedge clk) disable iff (rst)
    disp_fire |-> !pend[in_dst]);

  p_unit_claimed_r5: assert property (@(posedge clk) disable iff (rst)
    disp_fire |=> busy[$past(disp_unit)]);

  p_read_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (opr_go & ~busy) == '0);

  p_one_wb_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wb_go));

  p_wb_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (wb_go != '0) |-> ((wb_go & busy) == wb_go) && pend[wb_reg]);

  p_wb_clears_r10: assert property (@(posedge clk) disable iff (rst)
    (wb_go != '0) |=> !pend[$past(wb_reg)]);
endmodule

bind sb_issue_ctl sb_issue_chk #(.NFU(NFU), .UW(UW)) u_chk (
  .clk(clk), .rst(rst), .disp_fire(disp_fire), .disp_unit(disp_unit),
  .in_dst(in_dst), .opr_go(opr_go), .wb_go(wb_go), .wb_reg(wb_reg),
  .busy(busy), .pend(pend)
);

// File: tb/sb_issue_ctl_bench.sv
module sb_issue_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NFU = 4, NKIND = 2, KIND_W = 1, BASE_LAT = 2, LAT_STEP = 2, UW = 2;
  localparam int MAXP = 256;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [KIND_W-1:0] in_kind = '0;
  logic [2:0] in_dst = '0, in_srca = '0, in_srcb = '0;
  logic disp_fire;
  logic [UW-1:0] disp_unit;
  logic [NFU-1:0] opr_go, wb_go;
  logic [2:0] wb_reg;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sb_issue_ctl #(.NFU(NFU), .NKIND(NKIND), .KIND_W(KIND_W), .BASE_LAT(BASE_LAT),
                 .LAT_STEP(LAT_STEP), .UW(UW)) u_sb_issue_ctl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind), .in_dst(in_dst),
    .in_srca(in_srca), .in_srcb(in_srcb), .disp_fire(disp_fire), .disp_unit(disp_unit),
    .opr_go(opr_go), .wb_go(wb_go), .wb_reg(wb_reg));

  int total = 0, bad = 0;
  int p_kind[MAXP], p_d[MAXP], p_a[MAXP], p_b[MAXP];
  int plen, ip;
  int m_busy[NFU], m_rdn[NFU], m_rj[NFU], m_rk[NFU], m_fi[NFU], m_fj[NFU], m_fk[NFU];
  int m_qj[NFU], m_qk[NFU], m_run[NFU], m_cnt[NFU];
  int m_pend[8], m_prod[8];
  int n_war = 0, n_struct = 0, n_waw = 0, n_contend = 0, n_samecyc = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NFU; i++) begin
      m_busy[i] = 0; m_rdn[i] = 0; m_rj[i] = 0; m_rk[i] = 0; m_fi[i] = 0;
      m_fj[i] = 0; m_fk[i] = 0; m_qj[i] = 0; m_qk[i] = 0; m_run[i] = 0; m_cnt[i] = 0;
    end
    for (int r = 0; r < 8; r++) begin m_pend[r] = 0; m_prod[r] = 0; end
  endtask

  task automatic add(input int k, input int d, input int a, input int b);
    p_kind[plen] = k; p_d[plen] = d; p_a[plen] = a; p_b[plen] = b; plen++;
  endtask

  // one clock: entered just after a falling edge
  task automatic step();
    bit [NFU-1:0] e_opr;
    bit [NFU-1:0] e_wb;
    bit e_fire;
    int e_unit, wbu, wreg, nelig;
    bit blocked;
    e_opr = '0; e_wb = '0; e_fire = 1'b0; e_unit = -1; wbu = -1; wreg = 0; nelig = 0;
    if (ip < plen) begin
      in_valid = 1'b1; in_kind = KIND_W'(p_kind[ip]);
      in_dst = 3'(p_d[ip]); in_srca = 3'(p_a[ip]); in_srcb = 3'(p_b[ip]);
    end else in_valid = 1'b0;
    for (int i = 0; i < NFU; i++)
      if (m_busy[i] != 0 && m_rdn[i] == 0 && m_rj[i] != 0 && m_rk[i] != 0) e_opr[i] = 1'b1;
    for (int i = 0; i < NFU; i++) begin
      if (m_busy[i] != 0 && m_run[i] != 0 && m_cnt[i] == 0) begin
        blocked = 1'b0;
        for (int f = 0; f < NFU; f++)
          if (m_busy[f] != 0 && m_rdn[f] == 0 &&
              ((m_rj[f] != 0 && m_fj[f] == m_fi[i]) || (m_rk[f] != 0 && m_fk[f] == m_fi[i])))
            blocked = 1'b1;
        if (blocked) n_war++;
        else begin
          nelig++;
          if (wbu < 0) wbu = i;
        end
      end
    end
    if (nelig > 1) n_contend++;
    if (wbu >= 0) begin e_wb[wbu] = 1'b1; wreg = m_fi[wbu]; end
    if (ip < plen) begin
      for (int i = 0; i < NFU; i++)
        if (e_unit < 0 && m_busy[i] == 0 && (i % NKIND) == p_kind[ip]) e_unit = i;
      if (e_unit < 0) n_struct++;
      if (m_pend[p_d[ip]] != 0) n_waw++;
      e_fire = (e_unit >= 0) && (m_pend[p_d[ip]] == 0);
    end
    #1;
    check(disp_fire == e_fire, "R2/R3/R4 dispatch", int'(disp_fire), int'(e_fire));
    if (e_fire) check(int'(disp_unit) == e_unit, "R5 unit choice", int'(disp_unit), e_unit);
    check(opr_go == e_opr, "R6/R10 operand read", int'(opr_go), int'(e_opr));
    check(wb_go == e_wb, "R7/R8/R9 write-back grant", int'(wb_go), int'(e_wb));
    if (wbu >= 0) check(int'(wb_reg) == wreg, "R9 wb_reg", int'(wb_reg), wreg);
    // advance reference state
    for (int i = 0; i < NFU; i++) begin
      if (e_opr[i]) begin m_rdn[i] = 1; m_run[i] = 1; m_cnt[i] = BASE_LAT + LAT_STEP * i - 1; end
      else if (m_run[i] != 0 && m_cnt[i] > 0) m_cnt[i]--;
    end
    if (wbu >= 0) begin
      m_busy[wbu] = 0; m_rdn[wbu] = 0; m_run[wbu] = 0;
      for (int f = 0; f < NFU; f++) begin
        if (m_busy[f] != 0 && m_qj[f] == wbu) m_rj[f] = 1;
        if (m_busy[f] != 0 && m_qk[f] == wbu) m_rk[f] = 1;
      end
      m_pend[wreg] = 0;
    end
    if (e_fire) begin
      if (wbu >= 0 && (p_a[ip] == wreg || p_b[ip] == wreg)) n_samecyc++;
      m_busy[e_unit] = 1; m_rdn[e_unit] = 0;
      m_fi[e_unit] = p_d[ip]; m_fj[e_unit] = p_a[ip]; m_fk[e_unit] = p_b[ip];
      m_qj[e_unit] = m_prod[p_a[ip]]; m_qk[e_unit] = m_prod[p_b[ip]];
      m_rj[e_unit] = (m_pend[p_a[ip]] == 0) ? 1 : 0;
      m_rk[e_unit] = (m_pend[p_b[ip]] == 0) ? 1 : 0;
      m_pend[p_d[ip]] = 1; m_prod[p_d[ip]] = e_unit;
      ip++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_prog();
    int guard;
    bit idle;
    ip = 0; guard = 0;
    do begin
      step();
      guard++;
      idle = (ip >= plen);
      for (int i = 0; i < NFU; i++) if (m_busy[i] != 0) idle = 1'b0;
    end while (!idle && guard < 4000);
    check(idle, "R2 program drained", ip, plen);
    plen = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    plen = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(disp_fire == 1'b0, "R1 reset dispatch", int'(disp_fire), 0);
    check(opr_go == '0, "R1 reset operand read", int'(opr_go), 0);
    check(wb_go == '0, "R1 reset write-back", int'(wb_go), 0);
    @(negedge clk);
    // independent work, third kind-0 op waits for a free unit (R3, R5)
    add(0, 1, 0, 0); add(0, 2, 0, 0); add(0, 3, 0, 0); add(1, 4, 0, 0); add(1, 5, 0, 0);
    run_prog();
    // RAW chain across kinds (R6, R7)
    add(0, 1, 2, 3); add(1, 2, 1, 1); add(0, 3, 2, 1); add(1, 4, 3, 2);
    run_prog();
    // repeated writer of one register (R4)
    add(1, 5, 0, 0); add(0, 5, 1, 1); add(1, 6, 5, 5);
    run_prog();
    // fast writer must wait for a slow earlier reader (R8)
    add(1, 2, 0, 0); add(1, 3, 2, 1); add(0, 1, 0, 0); add(0, 4, 1, 3);
    run_prog();
    check(n_war > 0, "R8 hold observed", n_war, 1);
    // random stream (R9, R10)
    for (int n = 0; n < 200; n++)
      add(int'($urandom_range(NKIND - 1, 0)), int'($urandom_range(7, 0)),
          int'($urandom_range(7, 0)), int'($urandom_range(7, 0)));
    run_prog();
    check(n_struct > 0, "R3 stall observed", n_struct, 1);
    check(n_waw > 0, "R4 stall observed", n_waw, 1);
    check(n_contend > 0, "R9 contention observed", n_contend, 1);
    check(n_samecyc > 0, "R10 same-cycle release observed", n_samecyc, 1);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule